// File: doc/BRIEF.md
# Programmable Period/Duty PWM Generator

This block turns one input clock into a pulse-width-modulated line. A serial loader that sits outside the block hands it a period count, a high-time count, a halve-the-rate flag and a sleep flag, together with a one-cycle write strobe and a code that says how many of those fields the write carries. Every period opens with a high phase and closes with a low phase. New settings are staged in shadow registers and reach the counters only when the running period wraps. The exception is the first start and any restart, which take the staged values at once.

An over-threshold fault line is synchronised inside the block. When it is asserted, the output drops and the block stops. The stop is latched: the block runs again only after the fault has gone and a new write arrives. A sleep flag written by a complete load also stops counting and holds the line low. Until the first complete load has arrived, the line stays low.

Top module: `pwm_gen`

## Requirements
- R1: The output period is (F+1)×(D+1) clock cycles, where F is the period field and D is the divide-by-two flag.
- R2: Each period starts with a high phase of (H+1)×(D+1) cycles, where H is the high-time field. The rest of the period is low.
- R3: When H ≥ F the output stays high for the whole period and has no low phase.
- R4: Setting the divide-by-two flag (D=1) doubles both the high phase and the full period.
- R5: After reset the output stays low until the first complete load. A write with load_sel_i of 0 or 1 before that point leaves it low.
- R6: On the first complete load the output is still low at the first clock edge after the strobe and goes high at the second edge.
- R7: load_sel_i picks which fields a write carries: 0 = high time only, 1 = period and high time, 2 or 3 = all four fields. Fields outside the chosen set are ignored. While the block runs, written values take effect only at the next period wrap.
- R8: A complete load with the sleep flag set drives the output low by the second clock edge after the strobe and keeps it low. Writes with load_sel_i 0 or 1 do not wake the block. A complete load with the flag clear restarts it.
- R9: fault_i passes through a two-flop synchroniser. While it is held high, the output is low by the third clock edge.
- R10: A fault stop is latched. The output stays low after fault_i falls, and a write made while fault_i is still high does not restart the block. The first write after the fault has cleared restarts it.
- R11: Every restart (first load, after a fault, after sleep) begins a fresh period with its full high phase. A rising edge of the output happens only at the start of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock that is divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | One-cycle write strobe from the serial loader |
| load_sel_i | input | 2 | Field set of the write: 0 high time, 1 period+high, 2/3 all |
| period_i | input | W | Period field F |
| high_i | input | W | High-time field H |
| div2_i | input | 1 | Divide-by-two flag D |
| sleep_i | input | 1 | Sleep flag |
| fault_i | input | 1 | Asynchronous over-threshold fault, active high |
| pwm_o | output | 1 | Registered PWM output |

## Verification
If the period counter is wrong or misses its compare, the high or low run length changes in the very next period. If the shadow-to-active copy happens at the wrong time, the length of the period already in progress changes, and that shows up within one period of the write. If the stop latch is broken, the line rises again while the fault is held or soon after it falls, before any write has been made. If the field selection is wrong, a partial write changes the rate or wakes a sleeping block, and both effects show at the port within a few periods.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam int PWM_W_DEF = 8;

  typedef enum logic [1:0] {
    SEL_HIGH   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_ALL    = 2'd2,
    SEL_ALL_B  = 2'd3
  } load_sel_e;

  function automatic logic sel_is_full(input logic [1:0] sel);
    return sel[1];
  endfunction

  function automatic logic sel_has_period(input logic [1:0] sel);
    return sel != SEL_HIGH;
  endfunction

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage
  import pwm_gen_pkg::*;
#(
  parameter int W = PWM_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [1:0]   load_sel_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] high_i,
  input  logic         div2_i,
  input  logic         sleep_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] high_o,
  output logic         div2_o,
  output logic         sleep_o,
  output logic         armed_o,
  output logic         upd_o
);

  logic [W-1:0] per_q, per_d;
  logic [W-1:0] high_q, high_d;
  logic         div2_q, div2_d;
  logic         sleep_q, sleep_d;
  logic         armed_q, armed_d;
  logic         upd_q, upd_d;
  logic         wr_full, wr_period;

  always_comb begin
    wr_full   = load_i && sel_is_full(load_sel_i);
    wr_period = load_i && sel_has_period(load_sel_i);
    per_d     = wr_period ? period_i : per_q;
    high_d    = load_i ? high_i : high_q;
    div2_d    = wr_full ? div2_i : div2_q;
    sleep_d   = wr_full ? sleep_i : sleep_q;
    armed_d   = armed_q | wr_full;
    upd_d     = load_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= '0;
      high_q  <= '0;
      div2_q  <= 1'b0;
      sleep_q <= 1'b0;
      armed_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      per_q   <= per_d;
      high_q  <= high_d;
      div2_q  <= div2_d;
      sleep_q <= sleep_d;
      armed_q <= armed_d;
      upd_q   <= upd_d;
    end
  end

  assign period_o = per_q;
  assign high_o   = high_q;
  assign div2_o   = div2_q;
  assign sleep_o  = sleep_q;
  assign armed_o  = armed_q;
  assign upd_o    = upd_q;

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic div2_i,
  output logic tick_o
);

  logic phase_q, phase_d;

  always_comb begin
    if (clr_i) begin
      phase_d = 1'b0;
    end else if (en_i && div2_i) begin
      phase_d = ~phase_q;
    end else begin
      phase_d = phase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign tick_o = en_i && (!div2_i || phase_q);

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic         armed_i,
  input  logic         sleep_i,
  input  logic         fault_i,
  input  logic         tick_i,
  input  logic [W-1:0] per_s_i,
  input  logic [W-1:0] high_s_i,
  input  logic         div2_s_i,
  output logic         start_o,
  output logic         running_o,
  output logic         div2_a_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] per_a_o,
  output logic         pwm_o
);

  logic         run_q, run_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_a_q, per_a_d;
  logic [W-1:0] high_a_q, high_a_d;
  logic         div2_a_q, div2_a_d;
  logic         pwm_q, pwm_d;
  logic         start, stop, wrap;

  always_comb begin
    start    = upd_i && armed_i && !sleep_i && !fault_i && !run_q;
    stop     = run_q && (fault_i || sleep_i);
    wrap     = run_q && tick_i && (cnt_q == per_a_q);
    run_d    = run_q;
    cnt_d    = cnt_q;
    per_a_d  = per_a_q;
    high_a_d = high_a_q;
    div2_a_d = div2_a_q;
    if (start) begin
      run_d    = 1'b1;
      cnt_d    = '0;
      per_a_d  = per_s_i;
      high_a_d = high_s_i;
      div2_a_d = div2_s_i;
    end else if (stop) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d    = '0;
      per_a_d  = per_s_i;
      high_a_d = high_s_i;
      div2_a_d = div2_s_i;
    end else if (run_q && tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
    pwm_d = run_d && (cnt_d <= high_a_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      per_a_q  <= '0;
      high_a_q <= '0;
      div2_a_q <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      run_q    <= run_d;
      cnt_q    <= cnt_d;
      per_a_q  <= per_a_d;
      high_a_q <= high_a_d;
      div2_a_q <= div2_a_d;
      pwm_q    <= pwm_d;
    end
  end

  assign start_o   = start;
  assign running_o = run_q;
  assign div2_a_o  = div2_a_q;
  assign cnt_o     = cnt_q;
  assign per_a_o   = per_a_q;
  assign pwm_o     = pwm_q;

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int W           = PWM_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [1:0]   load_sel_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] high_i,
  input  logic         div2_i,
  input  logic         sleep_i,
  input  logic         fault_i,
  output logic         pwm_o
);

  logic         rst_n_int;
  logic         fault_s;
  logic [W-1:0] per_s, high_s;
  logic         div2_s, sleep_s, armed, upd;
  logic         tick, start, running, div2_a;
  logic [W-1:0] cnt, per_a;

  pwm_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_n_int)
  );

  pwm_sync #(.STAGES(SYNC_STAGES)) u_fault_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (fault_i),
    .q_o    (fault_s)
  );

  pwm_cfg_stage #(.W(W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .load_i     (load_i),
    .load_sel_i (load_sel_i),
    .period_i   (period_i),
    .high_i     (high_i),
    .div2_i     (div2_i),
    .sleep_i    (sleep_i),
    .period_o   (per_s),
    .high_o     (high_s),
    .div2_o     (div2_s),
    .sleep_o    (sleep_s),
    .armed_o    (armed),
    .upd_o      (upd)
  );

  pwm_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .en_i   (running),
    .clr_i  (start),
    .div2_i (div2_a),
    .tick_o (tick)
  );

  pwm_period_ctr #(.W(W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .upd_i     (upd),
    .armed_i   (armed),
    .sleep_i   (sleep_s),
    .fault_i   (fault_s),
    .tick_i    (tick),
    .per_s_i   (per_s),
    .high_s_i  (high_s),
    .div2_s_i  (div2_s),
    .start_o   (start),
    .running_o (running),
    .div2_a_o  (div2_a),
    .cnt_o     (cnt),
    .per_a_o   (per_a),
    .pwm_o     (pwm_o)
  );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pwm_o,
  input logic         fault_s,
  input logic         armed,
  input logic         sleep_s,
  input logic         upd,
  input logic         running,
  input logic [W-1:0] cnt,
  input logic [W-1:0] per_a
);

  // R5
  pwm_low_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !pwm_o);

  // R9
  pwm_fault_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_s |=> !pwm_o);

  // R8
  pwm_sleep_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_s |=> !pwm_o);

  // R10
  pwm_restart_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running) |-> $past(upd));

  // R11
  pwm_rise_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> (cnt == '0));

  // R7
  pwm_active_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $past(running) && cnt != '0) |-> $stable(per_a));

endmodule

bind pwm_gen pwm_gen_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pwm_o   (pwm_o),
  .fault_s (fault_s),
  .armed   (armed),
  .sleep_s (sleep_s),
  .upd     (upd),
  .running (running),
  .cnt     (cnt),
  .per_a   (per_a)
);

// File: tb/pwm_gen_test.sv
module pwm_gen_test;

  localparam int W   = 8;
  localparam int CYC = 10;
  localparam int NV  = 6;
  // F, H, D, expected high cycles, expected low cycles
  localparam int VEC [0:NV-1][0:4] = '{
    '{4, 1, 0,  2, 3},
    '{5, 3, 0,  4, 2},
    '{5, 3, 1,  8, 4},
    '{1, 0, 1,  2, 2},
    '{9, 0, 0,  1, 9},
    '{7, 6, 1, 14, 2}
  };

  logic         clk;
  logic         rst_n;
  logic         load;
  logic [1:0]   sel;
  logic [W-1:0] per;
  logic [W-1:0] hi;
  logic         d2;
  logic         slp;
  logic         flt;
  logic         pwm;

  int checks;
  int errors;
  bit done;

  pwm_gen #(.W(W)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .load_i     (load),
    .load_sel_i (sel),
    .period_i   (per),
    .high_i     (hi),
    .div2_i     (d2),
    .sleep_i    (slp),
    .fault_i    (flt),
    .pwm_o      (pwm)
  );

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input int f, input int h, input int dv, input int sl);
    @(negedge clk);
    load = 1'b1;
    sel  = s[1:0];
    per  = f[W-1:0];
    hi   = h[W-1:0];
    d2   = dv[0];
    slp  = sl[0];
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) c++;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    int   n;
    prev = pwm;
    n = 0;
    @(negedge clk);
    while (!(!prev && pwm) && n < 4000) begin
      prev = pwm;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int h, output int l);
    wait_rise();
    h = 0;
    l = 0;
    while (pwm && h < 4000) begin
      h++;
      @(negedge clk);
    end
    while (!pwm && l < 4000) begin
      l++;
      @(negedge clk);
    end
  endtask

  initial begin
    int h, l, c;
    checks = 0;
    errors = 0;
    done   = 0;
    load = 0; sel = 0; per = 0; hi = 0; d2 = 0; slp = 0; flt = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: reset state and partial writes before arming
    chk("R5 reset low", int'(pwm), 0);
    wr(0, 4, 1, 0, 0);
    wr(1, 4, 1, 0, 0);
    count_high(20, c);
    chk("R5 partial writes keep low", c, 0);

    // R6: first complete load timing
    wr(2, 4, 1, 0, 0);
    chk("R6 low after first edge", int'(pwm), 0);
    @(negedge clk);
    chk("R6 high after second edge", int'(pwm), 1);

    // R1 R2 R4: vector table
    for (int i = 0; i < NV; i++) begin
      wr(2, VEC[i][0], VEC[i][1], VEC[i][2], 0);
      measure(h, l);
      measure(h, l);
      chk(VEC[i][2] != 0 ? "R4 high phase" : "R2 high phase", h, VEC[i][3]);
      chk("R1 period", h + l, VEC[i][3] + VEC[i][4]);
    end

    // R3: high time not below period
    wr(2, 3, 7, 0, 0);
    repeat (20) @(negedge clk);
    count_high(40, c);
    chk("R3 no low phase", c, 40);

    // R7: deferred update of high time
    wr(2, 9, 0, 0, 0);
    measure(h, l);
    wait_rise();
    @(negedge clk);
    wr(0, 0, 4, 1, 1);
    count_high(4, c);
    chk("R7 no mid-period change", c, 0);
    measure(h, l);
    chk("R7 new high at wrap", h, 5);
    chk("R7 period kept on sel 0", h + l, 10);

    // R7: sel 1 ignores divide flag
    wr(2, 9, 0, 1, 0);
    measure(h, l);
    wr(1, 3, 1, 0, 1);
    measure(h, l);
    measure(h, l);
    chk("R7 sel 1 high keeps divide", h, 4);
    chk("R7 sel 1 period keeps divide", h + l, 8);

    // R8: sleep
    wr(2, 3, 1, 0, 1);
    @(negedge clk);
    chk("R8 low after sleep", int'(pwm), 0);
    count_high(30, c);
    chk("R8 stays low", c, 0);
    wr(1, 3, 1, 0, 0);
    count_high(30, c);
    chk("R8 partial does not wake", c, 0);
    wr(2, 3, 1, 0, 0);
    measure(h, l);
    chk("R8 wake high", h, 2);
    chk("R8 wake period", h + l, 4);

    // R9 R10 R11: fault
    wr(2, 9, 9, 0, 0);
    repeat (10) @(negedge clk);
    @(negedge clk);
    flt = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 low by third edge", int'(pwm), 0);
    wr(0, 9, 9, 0, 0);
    count_high(10, c);
    chk("R10 write during fault ignored", c, 0);
    flt = 1'b0;
    count_high(10, c);
    chk("R10 latched after release", c, 0);
    wr(1, 5, 2, 0, 0);
    @(negedge clk);
    chk("R10 restart by write", int'(pwm), 1);
    c = 0;
    while (pwm && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk("R11 full high phase on restart", c, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CYC * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule